// File: doc/BRIEF.md
# March Memory Test Sequencer

This block is a built-in self-test engine for a word-addressed static memory. It reaches the memory through a simple synchronous port: address, write data, write enable, read enable and read data, with the read data valid one cycle after the read request. A start pulse launches a complete March-style test. The engine first writes a background value into every word. It then sweeps upward through memory. At each word it reads, writes the inverse value, and reads again. It then sweeps downward and restores the background the same way. After that it repeats the whole test with the background inverted.

Every read is checked against the value the algorithm expects. The first mismatch is recorded: its address, the expected word and the word actually read. A sticky fail flag is set. A stop-on-error input decides what happens next. The engine either halts at once or runs to the end of the test. A done flag marks the end of the run and stays up until the next start. The default size is 8K words of 8 bits, with a 13-bit address. Both widths are parameters.

Top module: `march_bist`

## Requirements
- R1: After reset, `done`, `fail`, `mem_we` and `mem_re` are all low.
- R2: After an accepted start, the first phase writes the background to each address from 0 up to the top address, one write per cycle. The background is 0x00 (all bits low) in the first pass.
- R3: The second phase visits addresses in ascending order. At each address it issues three operations: a read expecting the background, a write of the inverted background, and a read expecting the inverted background.
- R4: The third phase visits addresses in descending order, starting at the top address. At each address it issues a read expecting the inverted background, a write of the background, and a read expecting the background.
- R5: After the first pass ends, the three phases run again with a background of all bits high (0xFF for 8-bit words).
- R6: A read's data is compared one cycle after the read request. On the first mismatch, `fail` goes high and stays high until the next accepted start. `fail_addr`, `fail_exp` and `fail_act` capture the address, expected word and actual word of that read.
- R7: With `stop_on_err` high, a mismatch ends the run. At most the one operation already issued completes, no further memory operations follow, and `done` rises.
- R8: With `stop_on_err` low, the run continues to the end after a mismatch. The captured address and data keep the values of the first mismatch.
- R9: `done` rises after the final read of the second pass has been compared, and holds until the next start. An accepted start clears `done` and `fail`.
- R10: Only one memory operation is issued per cycle, and never a read and a write together. A full run on N words issues exactly 14·N operations.
- R11: A start pulse arriving while a test is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse to begin a test (accepted when no test is running) |
| stop_on_err | input | 1 | 1: halt on first mismatch; 0: run to the end |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after `mem_re` |
| done | output | 1 | Test finished or halted |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_exp | output | DATA_W | Expected word of the first mismatch |
| fail_act | output | DATA_W | Word read at the first mismatch |

## Verification
The assertions assume that the attached memory returns read data exactly one cycle after a read request. They also assume that `stop_on_err` does not change during a run, because the halt check ties a mismatch to an immediate stop. The bench memory model registers its read data on the clock edge that samples `mem_re`, and it writes on the edge that samples `mem_we`. The bench sets `stop_on_err` and any injected stuck-bit fault only before it pulses start, so every run sees a fixed configuration.

// File: rtl/march_pkg.sv
package march_pkg;

  typedef enum logic [1:0] {
    PH_FILL = 2'd0,
    PH_UP   = 2'd1,
    PH_DOWN = 2'd2
  } phase_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } state_t;

  localparam logic [1:0] STEP_LAST = 2'd2;

endpackage

// File: rtl/march_addr.sv
module march_addr #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              load_top,
  input  logic              inc,
  input  logic              dec,
  output logic [ADDR_W-1:0] addr,
  output logic              at_top,
  output logic              at_bot
);

  localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] BOT = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= BOT;
    end else if (load) begin
      addr <= load_top ? TOP : BOT;
    end else if (inc) begin
      addr <= addr + 1'b1;
    end else if (dec) begin
      addr <= addr - 1'b1;
    end
  end

  assign at_top = (addr == TOP);
  assign at_bot = (addr == BOT);

  // R2 R3: the sequencer must reload instead of wrapping past the top
  p_no_wrap_up_r3: assert property (@(posedge clk) disable iff (rst)
    !(inc && at_top && !load));

  // R4: the sequencer must never step below address zero
  p_no_wrap_down_r4: assert property (@(posedge clk) disable iff (rst)
    !(dec && at_bot && !load));

endmodule

// File: rtl/march_ctrl.sv
module march_ctrl
  import march_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              halt,
  output logic              start_ok,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W-1:0] exp_data,
  output logic              done
);

  state_t            state;
  phase_t            phase;
  logic              pass;
  logic [1:0]        step;
  logic              drain;

  logic [ADDR_W-1:0] cur_addr;
  logic              at_top;
  logic              at_bot;
  logic              a_load;
  logic              a_top;
  logic              a_inc;
  logic              a_dec;

  logic [DATA_W-1:0] bg;
  logic              op_we;
  logic              op_re;
  logic [DATA_W-1:0] op_wdata;
  logic [DATA_W-1:0] op_exp;
  logic              run_go;
  logic              last_step;

  march_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .load     (a_load),
    .load_top (a_top),
    .inc      (a_inc),
    .dec      (a_dec),
    .addr     (cur_addr),
    .at_top   (at_top),
    .at_bot   (at_bot)
  );

  assign start_ok  = start && ((state == ST_IDLE) || (state == ST_DONE));
  assign run_go    = (state == ST_RUN) && !halt;
  assign last_step = (step == STEP_LAST);
  assign bg        = {DATA_W{pass}};
  assign done      = (state == ST_DONE);

  // operation for the current phase / step
  always_comb begin
    op_we    = 1'b0;
    op_re    = 1'b0;
    op_wdata = bg;
    op_exp   = bg;
    unique case (phase)
      PH_FILL: begin
        op_we    = 1'b1;
        op_wdata = bg;
      end
      PH_UP: begin
        unique case (step)
          2'd0:    begin op_re = 1'b1; op_exp = bg; end
          2'd1:    begin op_we = 1'b1; op_wdata = ~bg; end
          default: begin op_re = 1'b1; op_exp = ~bg; end
        endcase
      end
      default: begin
        unique case (step)
          2'd0:    begin op_re = 1'b1; op_exp = ~bg; end
          2'd1:    begin op_we = 1'b1; op_wdata = bg; end
          default: begin op_re = 1'b1; op_exp = bg; end
        endcase
      end
    endcase
  end

  // address sequencing
  always_comb begin
    a_load = 1'b0;
    a_top  = 1'b0;
    a_inc  = 1'b0;
    a_dec  = 1'b0;
    if (start_ok) begin
      a_load = 1'b1;
    end else if (run_go) begin
      unique case (phase)
        PH_FILL: begin
          if (at_top) a_load = 1'b1;
          else        a_inc  = 1'b1;
        end
        PH_UP: begin
          if (last_step) begin
            if (at_top) begin
              a_load = 1'b1;
              a_top  = 1'b1;
            end else begin
              a_inc = 1'b1;
            end
          end
        end
        default: begin
          if (last_step) begin
            if (at_bot) a_load = 1'b1;
            else        a_dec  = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      phase     <= PH_FILL;
      pass      <= 1'b0;
      step      <= 2'd0;
      drain     <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      exp_data  <= '0;
    end else begin
      mem_we <= 1'b0;
      mem_re <= 1'b0;
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (start_ok) begin
            state <= ST_RUN;
            phase <= PH_FILL;
            pass  <= 1'b0;
            step  <= 2'd0;
            drain <= 1'b0;
          end
        end
        ST_RUN: begin
          if (halt) begin
            state <= ST_DONE;
          end else begin
            mem_addr  <= cur_addr;
            mem_we    <= op_we;
            mem_re    <= op_re;
            mem_wdata <= op_wdata;
            exp_data  <= op_exp;
            if (phase == PH_FILL) begin
              if (at_top) begin
                phase <= PH_UP;
                step  <= 2'd0;
              end
            end else begin
              step <= last_step ? 2'd0 : step + 2'd1;
              if (last_step) begin
                if (phase == PH_UP && at_top) begin
                  phase <= PH_DOWN;
                end else if (phase == PH_DOWN && at_bot) begin
                  if (pass) begin
                    state <= ST_DRAIN;
                    drain <= 1'b0;
                  end else begin
                    pass  <= 1'b1;
                    phase <= PH_FILL;
                  end
                end
              end
            end
          end
        end
        default: begin
          if (halt || drain) state <= ST_DONE;
          else               drain <= 1'b1;
        end
      endcase
    end
  end

  // R10: one operation per cycle
  p_single_op_r10: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  // R9: a finished engine leaves the memory untouched
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!mem_we && !mem_re));

  // R3 R4: a march write is followed by a re-read of the same word
  p_reread_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_we && (phase != PH_FILL) && (step == 2'd2) && !halt)
      |=> (mem_re && $stable(mem_addr)));

endmodule

// File: rtl/march_chk.sv
module march_chk #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              stop_on_err,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_exp,
  input  logic [DATA_W-1:0] rdata,
  output logic              halt,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_exp,
  output logic [DATA_W-1:0] fail_act
);

  logic              pend;
  logic [ADDR_W-1:0] pend_addr;
  logic [DATA_W-1:0] pend_exp;
  logic              mismatch;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      pend      <= 1'b0;
      pend_addr <= '0;
      pend_exp  <= '0;
    end else begin
      pend      <= rd_req;
      pend_addr <= rd_addr;
      pend_exp  <= rd_exp;
    end
  end

  assign mismatch = pend && (rdata != pend_exp);
  assign halt     = mismatch && stop_on_err;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_exp  <= '0;
      fail_act  <= '0;
    end else if (mismatch && !fail) begin
      fail      <= 1'b1;
      fail_addr <= pend_addr;
      fail_exp  <= pend_exp;
      fail_act  <= rdata;
    end
  end

  // R6: the flag is sticky until a new start
  p_fail_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (fail && !clear) |=> fail);

  // R8: later mismatches leave the first capture alone
  p_capture_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (fail && !clear) |=> ($stable(fail_addr) && $stable(fail_exp) && $stable(fail_act)));

  // R6: first mismatch records the word that came back
  p_first_catch_r6: assert property (@(posedge clk) disable iff (rst)
    (mismatch && !fail && !clear) |=> (fail && (fail_act == $past(rdata))));

endmodule

// File: rtl/march_bist.sv
module march_bist #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stop_on_err,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [DATA_W-1:0] fail_exp,
  output logic [DATA_W-1:0] fail_act
);

  logic              halt;
  logic              start_ok;
  logic [DATA_W-1:0] exp_data;

  march_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .halt      (halt),
    .start_ok  (start_ok),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .exp_data  (exp_data),
    .done      (done)
  );

  march_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .clear       (start_ok),
    .stop_on_err (stop_on_err),
    .rd_req      (mem_re),
    .rd_addr     (mem_addr),
    .rd_exp      (exp_data),
    .rdata       (mem_rdata),
    .halt        (halt),
    .fail        (fail),
    .fail_addr   (fail_addr),
    .fail_exp    (fail_exp),
    .fail_act    (fail_act)
  );

  // R7: a halting mismatch stops memory traffic and raises done
  p_halt_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (halt && !start) |=> (done && !mem_we && !mem_re));

endmodule

// File: tb/march_bist_tb.sv
`timescale 1ns/1ps
module march_bist_tb;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic          stop_on_err = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic          mem_we;
  logic          mem_re;
  logic [DW-1:0] mem_rdata;
  logic          done;
  logic          fail;
  logic [AW-1:0] fail_addr;
  logic [DW-1:0] fail_exp;
  logic [DW-1:0] fail_act;

  int checks = 0;
  int errors = 0;
  int op_idx = 0;
  int seq_err = 0;

  logic          flt_en = 1'b0;
  logic [AW-1:0] flt_addr = '0;
  logic [DW-1:0] flt_and = '1;
  logic [DW-1:0] flt_or = '0;
  logic [DW-1:0] mem [N];

  always #2.5 clk = ~clk;

  march_bist #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .stop_on_err(stop_on_err),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_re(mem_re), .mem_rdata(mem_rdata), .done(done), .fail(fail),
    .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_act(fail_act)
  );

  // memory model: one-cycle read latency, optional stuck bits on one word
  always_ff @(posedge clk) begin
    if (mem_we) begin
      if (flt_en && mem_addr == flt_addr) mem[mem_addr] <= (mem_wdata & flt_and) | flt_or;
      else                                mem[mem_addr] <= mem_wdata;
    end
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  // expected operation number idx of a full run
  function automatic void exp_op(input int idx, output int a, output bit w, output logic [DW-1:0] d);
    int r;
    logic [DW-1:0] b;
    b = ((idx / (7*N)) != 0) ? '1 : '0;
    r = idx % (7*N);
    if (r < N) begin
      a = r; w = 1'b1; d = b;
    end else if (r < 4*N) begin
      r = r - N;
      a = r / 3; w = (r % 3) == 1; d = ~b;
    end else begin
      r = r - 4*N;
      a = N - 1 - r / 3; w = (r % 3) == 1; d = b;
    end
  endfunction

  always @(negedge clk) begin
    if (!rst && (mem_we || mem_re)) begin
      int a; bit w; logic [DW-1:0] d;
      exp_op(op_idx, a, w, d);
      if (mem_addr != a[AW-1:0] || mem_we != w || mem_re != !w || (w && mem_wdata != d))
        seq_err++;
      op_idx++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 4000 && !done; i++) @(negedge clk);
  endtask

  task automatic launch(input bit stop);
    stop_on_err = stop;
    @(negedge clk);
    op_idx = 0;
    seq_err = 0;
    pulse_start();
    chk(done == 1'b0 && fail == 1'b0, "R9 start clears done/fail", {done, fail}, 0);
  endtask

  task automatic t_reset();
    chk(!done && !fail && !mem_we && !mem_re, "R1 reset state",
        {done, fail, mem_we, mem_re}, 0);
  endtask

  task automatic t_clean();
    flt_en = 1'b0;
    launch(1'b0);
    wait_done();
    chk(done, "R9 done after full run", done, 1);
    chk(seq_err == 0, "R2 R3 R4 R5 operation order", seq_err, 0);
    chk(op_idx == 14*N, "R10 op count", op_idx, 14*N);
    chk(!fail, "R6 no fail on good memory", fail, 0);
    repeat (20) @(negedge clk);
    chk(done && op_idx == 14*N, "R9 done holds, no traffic", op_idx, 14*N);
  endtask

  task automatic t_stuck_stop();
    flt_en = 1'b1; flt_addr = 4'd5; flt_and = '1; flt_or = 8'h01;
    launch(1'b1);
    wait_done();
    chk(fail && fail_addr == 5, "R6 fail address", fail_addr, 5);
    chk(fail_exp == 8'h00 && fail_act == 8'h01, "R6 fail data", {fail_exp, fail_act}, 16'h0001);
    repeat (10) @(negedge clk);
    chk(done && op_idx == N + 3*5 + 2, "R7 halt after in-flight op", op_idx, N + 17);
    chk(seq_err == 0, "R3 order up to halt", seq_err, 0);
  endtask

  task automatic t_stuck_continue();
    flt_en = 1'b1; flt_addr = 4'd5; flt_and = '1; flt_or = 8'h01;
    launch(1'b0);
    wait_done();
    chk(done && op_idx == 14*N, "R8 run completes", op_idx, 14*N);
    chk(fail && fail_addr == 5 && fail_exp == 8'h00 && fail_act == 8'h01,
        "R8 first capture kept", {fail_addr, fail_exp, fail_act}, {4'd5, 16'h0001});
  endtask

  task automatic t_top_fault();
    flt_en = 1'b1; flt_addr = 4'(N-1); flt_and = 8'h7F; flt_or = 8'h00;
    launch(1'b1);
    wait_done();
    chk(fail && fail_addr == 4'(N-1), "R3 fault at top address", fail_addr, N-1);
    chk(fail_exp == 8'hFF && fail_act == 8'h7F, "R6 ones read mismatch", {fail_exp, fail_act}, 16'hFF7F);
  endtask

  task automatic t_down_fault();
    // only a 0 -> 1 transition failure: bit 3 of word 2 cannot be set after it is cleared
    // detected first on the up-element re-read, expected FF
    flt_en = 1'b1; flt_addr = 4'd2; flt_and = 8'hF7; flt_or = 8'h00;
    launch(1'b1);
    wait_done();
    chk(fail && fail_addr == 2 && fail_act == 8'hF7, "R4 R5 stuck-low bit", {fail_addr, fail_act}, {4'd2, 8'hF7});
  endtask

  task automatic t_restart_ignored();
    flt_en = 1'b0;
    launch(1'b0);
    while (op_idx < 50) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done();
    chk(op_idx == 14*N && seq_err == 0, "R11 start while running ignored", op_idx, 14*N);
    chk(!fail, "R9 fail cleared by new start", fail, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_clean();
    t_stuck_stop();
    t_stuck_continue();
    t_top_fault();
    t_down_fault();
    t_restart_ignored();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule